// File: doc/BRIEF.md
# Single-Precision to 16-Bit Float Packer

This block takes a 32-bit IEEE single-precision word and compresses it into a 16-bit short float made of a sign bit, a 4-bit exponent and an 11-bit fraction. The packed layout is sign in bit 15, exponent in bits 14:11 and fraction in bits 10:0. The input source exponent (bits 30:23 of the input, biased by 127) selects one of four ranges:

- Large values clamp to the largest magnitude.
- The normal range keeps its exponent by bit selection rather than by re-biasing.
- A band just below the normal range underflows gradually into denormals, which keep the hidden one.
- Anything smaller flushes to a signed zero.

Every kept fraction is rounded to nearest, with ties going to even.

A producer presents a word together with a valid strobe. The packed word appears on a registered output one clock later, flagged by its own valid strobe. Words can be streamed every cycle. When no word is offered, the output word keeps its last value.

Top module: `sfp_pack`

## Requirements
- R1: Output bit 15 equals input bit 31 for every input word.
- R2: A source exponent above 135 gives exponent and fraction fields of all ones (magnitude 0x7FFF).
- R3: A source exponent of 121 to 135 gives a packed exponent equal to the source exponent minus 120, which is the same as the source exponent MSB followed by its three LSBs. The packed fraction is input bits 22:12, rounded using input bit 11 as guard and the OR of bits 10:0 as sticky.
- R4: Rounding is to nearest. When the guard bit is 1 and the sticky bit is 0, the fraction rounds up only if its least significant kept bit is 1.
- R5: A rounding carry out of an 11-bit normal fraction clears the fraction and adds one to the exponent. If the exponent is already 15, the result is the largest magnitude 0x7FFF instead.
- R6: A source exponent of 110 to 120 gives exponent 0. The fraction is the hidden one followed by the top (exponent − 110) source fraction bits, right-aligned, and rounded as in R4 on the discarded bits.
- R7: A rounding carry out of a denormal fraction gives exponent 1 and fraction 0.
- R8: A source exponent below 110 gives exponent and fraction fields of zero.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and `out_word` changes only then. With `in_valid` low, `out_word` holds whatever `in_word` does.
- R10: Synchronous active-high reset clears `out_valid` and `out_word` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_word | input | 32 | Single-precision source word |
| out_valid | output | 1 | Packed word is valid this cycle |
| out_word | output | 16 | Packed short float {sign, exponent, fraction} |

## Verification
There is no internal state beyond the output register, so a wrong range decision, shift amount or rounding carry shows on `out_word` in the very cycle its `out_valid` rises. A stuck or lost valid bit, or a register that loads while idle, shows within one cycle of the stimulus that should have moved it. The sweep covers every source exponent with fraction patterns built to land on ties, sticky bits and carries. As a result, a mistake at any range boundary or in any rounding branch is seen on the next output.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int IN_EXP_W   = 8;
  localparam int IN_FRAC_W  = 23;
  localparam int OUT_EXP_W  = 4;
  localparam int OUT_FRAC_W = 11;
  localparam int IN_W       = 1 + IN_EXP_W + IN_FRAC_W;
  localparam int OUT_W      = 1 + OUT_EXP_W + OUT_FRAC_W;
  localparam int SAT_ABOVE  = 135;
  localparam int NORM_LO    = 121;
  localparam int DEN_LO     = 110;

  typedef enum logic [1:0] {
    RNG_ZERO = 2'd0,
    RNG_DEN  = 2'd1,
    RNG_NORM = 2'd2,
    RNG_SAT  = 2'd3
  } range_e;
endpackage

// File: rtl/sfp_range_classify.sv
module sfp_range_classify
  import sfp_pkg::*;
#(
  parameter int EXP_W     = IN_EXP_W,
  parameter int SAT_LIM   = SAT_ABOVE,
  parameter int NORM_MIN  = NORM_LO,
  parameter int DEN_MIN   = DEN_LO
) (
  input  logic [EXP_W-1:0] exp_i,
  output range_e           rng_o
);
  localparam logic [EXP_W-1:0] SAT_C  = EXP_W'(SAT_LIM);
  localparam logic [EXP_W-1:0] NORM_C = EXP_W'(NORM_MIN);
  localparam logic [EXP_W-1:0] DEN_C  = EXP_W'(DEN_MIN);

  always_comb begin
    if (exp_i > SAT_C)        rng_o = RNG_SAT;
    else if (exp_i >= NORM_C) rng_o = RNG_NORM;
    else if (exp_i >= DEN_C)  rng_o = RNG_DEN;
    else                      rng_o = RNG_ZERO;
  end
endmodule

// File: rtl/sfp_rne_round.sv
module sfp_rne_round #(
  parameter int W = 11
) (
  input  logic [W-1:0] kept_i,
  input  logic         guard_i,
  input  logic         sticky_i,
  output logic [W:0]   sum_o
);
  logic up;
  always_comb begin
    up    = guard_i & (sticky_i | kept_i[0]);
    sum_o = {1'b0, kept_i} + {{W{1'b0}}, up};
  end
endmodule

// File: rtl/sfp_denorm_align.sv
module sfp_denorm_align
  import sfp_pkg::*;
#(
  parameter int EXP_W   = IN_EXP_W,
  parameter int FRAC_W  = IN_FRAC_W,
  parameter int KEEP_W  = OUT_FRAC_W,
  parameter int DEN_MIN = DEN_LO
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              en_i,
  output logic [KEEP_W-1:0] kept_o,
  output logic              guard_o,
  output logic              sticky_o
);
  localparam int MW  = FRAC_W + 1;
  localparam int SHW = $clog2(MW + 1);
  localparam logic [EXP_W-1:0] DEN_C  = EXP_W'(DEN_MIN);
  localparam logic [EXP_W-1:0] KMAX_C = EXP_W'(KEEP_W - 1);

  logic [EXP_W-1:0] k_raw;
  logic [EXP_W-1:0] k;
  logic [SHW-1:0]   sh;
  logic [MW-1:0]    mant;
  logic [MW-1:0]    shifted;
  logic [MW-1:0]    low_mask;

  always_comb begin
    mant     = {1'b1, frac_i};
    k_raw    = exp_i - DEN_C;
    k        = (en_i && (k_raw <= KMAX_C)) ? k_raw : '0;
    sh       = SHW'(FRAC_W) - SHW'(k);
    shifted  = mant >> sh;
    kept_o   = shifted[KEEP_W-1:0];
    guard_o  = mant[sh - SHW'(1)];
    low_mask = (MW'(1) << (sh - SHW'(1))) - MW'(1);
    sticky_o = |(mant & low_mask);
  end
endmodule

// File: rtl/sfp_pack.sv
module sfp_pack
  import sfp_pkg::*;
#(
  parameter int EXP_IN_W   = IN_EXP_W,
  parameter int FRAC_IN_W  = IN_FRAC_W,
  parameter int EXP_OUT_W  = OUT_EXP_W,
  parameter int FRAC_OUT_W = OUT_FRAC_W,
  localparam int WI = 1 + EXP_IN_W + FRAC_IN_W,
  localparam int WO = 1 + EXP_OUT_W + FRAC_OUT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [WI-1:0] in_word,
  output logic          out_valid,
  output logic [WO-1:0] out_word
);
  localparam int DROP = FRAC_IN_W - FRAC_OUT_W;

  logic                  sgn;
  logic [EXP_IN_W-1:0]   src_exp;
  logic [FRAC_IN_W-1:0]  src_frac;
  range_e                rng;

  logic [EXP_OUT_W-1:0]  n_exp;
  logic [FRAC_OUT_W-1:0] n_kept;
  logic                  n_guard, n_sticky;
  logic [FRAC_OUT_W:0]   n_sum;

  logic [FRAC_OUT_W-1:0] d_kept;
  logic                  d_guard, d_sticky;
  logic [FRAC_OUT_W:0]   d_sum;

  logic [WO-2:0]         mag;

  assign sgn      = in_word[WI-1];
  assign src_exp  = in_word[WI-2 -: EXP_IN_W];
  assign src_frac = in_word[FRAC_IN_W-1:0];

  sfp_range_classify #(.EXP_W(EXP_IN_W)) u_cls (
    .exp_i (src_exp),
    .rng_o (rng)
  );

  // Normal path: exponent by bit selection, fraction by truncation plus rounding.
  assign n_exp    = {src_exp[EXP_IN_W-1], src_exp[EXP_OUT_W-2:0]};
  assign n_kept   = src_frac[FRAC_IN_W-1 -: FRAC_OUT_W];
  assign n_guard  = src_frac[DROP-1];
  assign n_sticky = |src_frac[DROP-2:0];

  sfp_rne_round #(.W(FRAC_OUT_W)) u_rnd_norm (
    .kept_i   (n_kept),
    .guard_i  (n_guard),
    .sticky_i (n_sticky),
    .sum_o    (n_sum)
  );

  // Denormal path: hidden one restored and shifted right.
  sfp_denorm_align #(
    .EXP_W  (EXP_IN_W),
    .FRAC_W (FRAC_IN_W),
    .KEEP_W (FRAC_OUT_W)
  ) u_align (
    .exp_i    (src_exp),
    .frac_i   (src_frac),
    .en_i     (rng == RNG_DEN),
    .kept_o   (d_kept),
    .guard_o  (d_guard),
    .sticky_o (d_sticky)
  );

  sfp_rne_round #(.W(FRAC_OUT_W)) u_rnd_den (
    .kept_i   (d_kept),
    .guard_i  (d_guard),
    .sticky_i (d_sticky),
    .sum_o    (d_sum)
  );

  always_comb begin
    unique case (rng)
      RNG_SAT:  mag = '1;
      RNG_NORM: begin
        if (n_sum[FRAC_OUT_W]) begin
          if (&n_exp) mag = '1;
          else        mag = {n_exp + EXP_OUT_W'(1), {FRAC_OUT_W{1'b0}}};
        end else begin
          mag = {n_exp, n_sum[FRAC_OUT_W-1:0]};
        end
      end
      RNG_DEN: begin
        if (d_sum[FRAC_OUT_W]) mag = {EXP_OUT_W'(1), {FRAC_OUT_W{1'b0}}};
        else                   mag = {{EXP_OUT_W{1'b0}}, d_sum[FRAC_OUT_W-1:0]};
      end
      default:  mag = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= {sgn, mag};
    end
  end
endmodule

// File: rtl/sfp_pack_chk.sv
module sfp_pack_chk
  import sfp_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_word,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_word
);
  logic [IN_EXP_W-1:0] e_in;
  assign e_in = in_word[IN_W-2 -: IN_EXP_W];

  // R1
  sign_copy_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_word[OUT_W-1] == $past(in_word[IN_W-1]));

  // R2
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && e_in > IN_EXP_W'(SAT_ABOVE)) |=> &out_word[OUT_W-2:0]);

  // R8
  flush_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && e_in < IN_EXP_W'(DEN_LO)) |=> out_word[OUT_W-2:0] == '0);

  // R6
  denorm_exp_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && e_in >= IN_EXP_W'(DEN_LO) && e_in < IN_EXP_W'(NORM_LO - 1))
    |=> out_word[OUT_W-2 -: OUT_EXP_W] == '0);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_word)));
endmodule

bind sfp_pack sfp_pack_chk u_sfp_pack_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_word   (in_word),
  .out_valid (out_valid),
  .out_word  (out_word)
);

// File: tb/sfp_pack_bench.sv
module sfp_pack_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic [15:0] out_word;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sfp_pack u_sfp_pack (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_word  (out_word)
  );

  logic [22:0] pats [12] = '{23'h000000, 23'h7FFFFF, 23'h000800, 23'h001800,
                             23'h000801, 23'h0007FF, 23'h400000, 23'h2AAAAA,
                             23'h555555, 23'h7FF800, 23'h7FF000, 23'h123456};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Arithmetic reference: returns packed magnitude and the requirement it exercises.
  function automatic logic [14:0] model(input logic [31:0] w, output string tag);
    int e, f, ex, q, r, div, half, m;
    bit up;
    e = int'(w[30:23]);
    f = int'(w[22:0]);
    if (e > 135) begin
      tag = "R2"; return 15'h7FFF;
    end else if (e >= 121) begin
      ex = e - 120;
      q = f / 4096; r = f % 4096;
      up = (r > 2048) || (r == 2048 && (q % 2) == 1);
      tag = (r == 2048) ? "R4" : "R3";
      q = q + int'(up);
      if (q == 2048) begin
        tag = "R5";
        if (ex == 15) return 15'h7FFF;
        ex = ex + 1; q = 0;
      end
      return 15'(ex * 2048 + q);
    end else if (e >= 110) begin
      m = f + 8388608;
      div = 1 << (23 - (e - 110));
      half = div / 2;
      q = m / div; r = m % div;
      up = (r > half) || (r == half && (q % 2) == 1);
      q = q + int'(up);
      tag = "R6";
      if (q == 2048) begin
        tag = "R7"; return 15'h0800;
      end
      return 15'(q);
    end
    tag = "R8";
    return 15'h0000;
  endfunction

  logic [15:0] last_exp;

  task automatic send(input logic [31:0] w);
    string tag;
    logic [14:0] mag;
    mag = model(w, tag);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    last_exp = {w[31], mag};
    chk("R9 valid", {31'b0, out_valid}, 32'd1);
    chk(tag, {17'b0, out_word[14:0]}, {17'b0, mag});
    chk("R1 sign", {31'b0, out_word[15]}, {31'b0, w[31]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {31'b0, out_valid}, 32'd0);
    chk("R10 reset word", {16'b0, out_word}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 idle after reset", {31'b0, out_valid}, 32'd0);

    for (int e = 0; e < 256; e++) begin
      for (int p = 0; p < 12; p++) begin
        for (int s = 0; s < 2; s++) begin
          send({s[0], e[7:0], pats[p]});
        end
      end
      // Idle cycle with a changed input word: output must hold (R9).
      in_word = ~in_word;
      @(negedge clk);
      chk("R9 idle valid", {31'b0, out_valid}, 32'd0);
      chk("R9 idle hold", {16'b0, out_word}, {16'b0, last_exp});
    end

    // Explicit boundary corners.
    send({1'b0, 8'd135, 23'h7FF800});   // R5 carry at top exponent saturates
    send({1'b1, 8'd134, 23'h7FFFFF});   // R5 carry into exponent 15
    send({1'b0, 8'd120, 23'h7FF000});   // R7 denormal carry
    send({1'b0, 8'd121, 23'h000800});   // R4 tie, even kept
    send({1'b1, 8'd109, 23'h7FFFFF});   // R8 just below denormal band
    send({1'b0, 8'd136, 23'h000000});   // R2 just above normal band

    // Reset in mid-stream clears the output (R10).
    rst = 1'b1;
    in_valid = 1'b1;
    in_word = {1'b1, 8'd130, 23'h123456};
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 mid reset valid", {31'b0, out_valid}, 32'd0);
    chk("R10 mid reset word", {16'b0, out_word}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule